// File: doc/BRIEF.md
# Fractional Baud Reference and Oversampling Tick Generator

This block turns a fast system clock into the timing strobes a serial port needs, without producing any derived clock. A 12-bit phase register gains a fixed increment on every system cycle. Each carry out of the register gives a one-cycle reference strobe. With the default increment of 151 on a 4096-step wheel, the strobe arrives on average once every 27.1258 cycles. At 50 MHz this is about 1.843262 MHz, close to the nominal 1.8432 MHz that all standard baud rates divide into evenly.

A programmable integer divider, set by a 3-bit rate code, turns the reference strobe into a sixteen-times oversampling strobe for a receiver. A fixed divide-by-16 stage then gives a once-per-bit strobe for a transmitter. All three outputs are clock enables in the system clock domain. A change of the rate code clears both dividers, so the new rate starts from a clean phase.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst` is high at a clock edge, all three outputs are low after that edge, and the phase register and both divider counts restart from zero.
- R2: `ref_tick` is never high in two consecutive cycles. After E clock edges counted from reset release, exactly floor(151·E/4096) reference strobes have been seen (1510 after 40960 edges).
- R3: After the first reference strobe, consecutive reference strobes are 27 or 28 cycles apart, so the jitter is at most one system cycle.
- R4: `os_tick` is high in the cycle after every N-th reference strobe. N follows the rate code: 0→1 (115200), 1→2 (57600), 2→3 (38400), 3→6 (19200), 4→12 (9600), 5→24 (4800), 6→48 (2400), 7→96 (1200). In other words, N = 1843200 / (16·baud).
- R5: `bit_tick` is high in the cycle after every 16th `os_tick`.
- R6: When `baud_sel` differs from the value it had at the previous edge, both dividers clear. Neither `os_tick` nor `bit_tick` is high after that edge, and the reference strobe present at that edge is not counted. The first `os_tick` under the new code comes after exactly N further reference strobes.
- R7: `os_tick` is high only in the cycle right after a `ref_tick`, and `bit_tick` only in the cycle right after an `os_tick`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_sel | input | 3 | Rate code selecting the oversampling divisor |
| ref_tick | output | 1 | One-cycle reference strobe, about 1.8432 MHz on average |
| os_tick | output | 1 | One-cycle strobe at sixteen times the selected baud rate |
| bit_tick | output | 1 | One-cycle strobe at the selected baud rate |

## Verification
Each output is one register stage after the event that causes it. The reference strobe appears after the edge at which the phase carries. `os_tick` appears one edge after the reference strobe it counts, and `bit_tick` one edge after the oversampling strobe it counts. A rate change suppresses both divided strobes at the very edge where the new code is first seen. The bench drives inputs on the falling edge and samples one nanosecond after each rising edge. At every sample it compares all three outputs against a cycle model built from these latencies. Window counts are read two nanoseconds after the last edge of a window, so every strobe already produced is included.

// File: rtl/baud_ref_pkg.sv
package baud_ref_pkg;

    localparam int SEL_W    = 3;
    localparam int MAX_DIV  = 96;
    localparam int DIV_W    = $clog2(MAX_DIV + 1);
    localparam int OS_RATIO = 16;
    localparam int OS_W     = $clog2(OS_RATIO + 1);

    typedef enum logic [SEL_W-1:0] {
        RATE_115200 = 3'd0,
        RATE_57600  = 3'd1,
        RATE_38400  = 3'd2,
        RATE_19200  = 3'd3,
        RATE_9600   = 3'd4,
        RATE_4800   = 3'd5,
        RATE_2400   = 3'd6,
        RATE_1200   = 3'd7
    } rate_code_e;

    // Reference strobes per oversampling strobe for each rate code.
    function automatic logic [DIV_W-1:0] ref_divisor(input rate_code_e code);
        logic [DIV_W-1:0] n;
        case (code)
            RATE_115200: n = DIV_W'(1);
            RATE_57600:  n = DIV_W'(2);
            RATE_38400:  n = DIV_W'(3);
            RATE_19200:  n = DIV_W'(6);
            RATE_9600:   n = DIV_W'(12);
            RATE_4800:   n = DIV_W'(24);
            RATE_2400:   n = DIV_W'(48);
            default:     n = DIV_W'(96);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/baud_phase_acc.sv
module baud_phase_acc #(
    parameter int PHASE_W   = 12,
    parameter int PHASE_INC = 151
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    logic [PHASE_W-1:0] phase;
    logic [PHASE_W:0]   next_sum;

    // The carry bit holds the overflow weight; the low bits keep the remainder.
    assign next_sum = {1'b0, phase} + (PHASE_W+1)'(PHASE_INC);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            tick  <= 1'b0;
        end else begin
            phase <= next_sum[PHASE_W-1:0];
            tick  <= next_sum[PHASE_W];
        end
    end
endmodule

// File: rtl/baud_tick_div.sv
module baud_tick_div #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick_in,
    input  logic [CNT_W-1:0] ratio,
    output logic             tick_out
);
    logic [CNT_W-1:0] cnt;
    logic             at_last;

    assign at_last = (cnt == ratio - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt      <= '0;
            tick_out <= 1'b0;
        end else if (tick_in) begin
            if (at_last) begin
                cnt      <= '0;
                tick_out <= 1'b1;
            end else begin
                cnt      <= cnt + 1'b1;
                tick_out <= 1'b0;
            end
        end else begin
            tick_out <= 1'b0;
        end
    end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_ref_pkg::*;
#(
    parameter int PHASE_W   = 12,
    parameter int PHASE_INC = 151
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] baud_sel,
    output logic             ref_tick,
    output logic             os_tick,
    output logic             bit_tick
);
    rate_code_e       sel_q;
    logic             rate_change;
    logic [DIV_W-1:0] os_ratio;

    always_ff @(posedge clk) begin
        if (rst) sel_q <= rate_code_e'(baud_sel);
        else     sel_q <= rate_code_e'(baud_sel);
    end

    assign rate_change = !rst && (rate_code_e'(baud_sel) != sel_q);
    assign os_ratio    = ref_divisor(sel_q);

    baud_phase_acc #(
        .PHASE_W  (PHASE_W),
        .PHASE_INC(PHASE_INC)
    ) u_phase (
        .clk (clk),
        .rst (rst),
        .tick(ref_tick)
    );

    baud_tick_div #(
        .CNT_W(DIV_W)
    ) u_os_div (
        .clk     (clk),
        .rst     (rst),
        .clr     (rate_change),
        .tick_in (ref_tick),
        .ratio   (os_ratio),
        .tick_out(os_tick)
    );

    baud_tick_div #(
        .CNT_W(OS_W)
    ) u_bit_div (
        .clk     (clk),
        .rst     (rst),
        .clr     (rate_change),
        .tick_in (os_tick),
        .ratio   (OS_W'(OS_RATIO)),
        .tick_out(bit_tick)
    );
endmodule

// File: rtl/baud_tick_gen_checker.sv
module baud_tick_gen_checker #(
    parameter int PHASE_W   = 12,
    parameter int PHASE_INC = 151
) (
    input logic       clk,
    input logic       rst,
    input logic [2:0] baud_sel,
    input logic       ref_tick,
    input logic       os_tick,
    input logic       bit_tick
);
    localparam int WHEEL    = 1 << PHASE_W;
    localparam int SPACE_LO = WHEEL / PHASE_INC;
    localparam int SPACE_HI = (WHEEL % PHASE_INC == 0) ? SPACE_LO : SPACE_LO + 1;

    logic [15:0] quiet_run;
    logic        seen_ref;

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_run <= '0;
            seen_ref  <= 1'b0;
        end else if (ref_tick) begin
            quiet_run <= '0;
            seen_ref  <= 1'b1;
        end else if (quiet_run != 16'hFFFF) begin
            quiet_run <= quiet_run + 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!ref_tick && !os_tick && !bit_tick));

    assert_ref_single_R2: assert property (@(posedge clk) disable iff (rst)
        ref_tick |=> !ref_tick);

    assert_ref_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        (ref_tick && seen_ref) |->
            (quiet_run >= 16'(SPACE_LO - 1) && quiet_run <= 16'(SPACE_HI - 1)));

    assert_os_follows_ref_R7: assert property (@(posedge clk) disable iff (rst)
        os_tick |-> $past(ref_tick));

    assert_bit_follows_os_R7: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> $past(os_tick));

    assert_change_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (baud_sel != $past(baud_sel)) |=> (!os_tick && !bit_tick));
endmodule

bind baud_tick_gen baud_tick_gen_checker #(
    .PHASE_W  (PHASE_W),
    .PHASE_INC(PHASE_INC)
) u_checker (
    .clk     (clk),
    .rst     (rst),
    .baud_sel(baud_sel),
    .ref_tick(ref_tick),
    .os_tick (os_tick),
    .bit_tick(bit_tick)
);

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
    localparam int REF_HZ = 1843200;
    localparam int BAUD_TAB [8] = '{115200, 57600, 38400, 19200, 9600, 4800, 2400, 1200};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] baud_sel = 3'd0;
    logic       ref_tick, os_tick, bit_tick;

    int total = 0;
    int bad   = 0;

    // cycle model state
    int m_phase = 0, m_cnt = 0, m_bcnt = 0, m_sel = 0;
    bit m_ref = 0, m_os = 0, m_bit = 0;
    int err_ref = 0, err_os = 0, err_bit = 0;
    int ref_total = 0, ref_win = 0, os_win = 0, bit_win = 0;
    int last_ref = -1, gap_min = 1000, gap_max = 0, cyc = 0;

    always #2 clk = ~clk;

    baud_tick_gen u_dut (
        .clk     (clk),
        .rst     (rst),
        .baud_sel(baud_sel),
        .ref_tick(ref_tick),
        .os_tick (os_tick),
        .bit_tick(bit_tick)
    );

    function automatic int div_of(input int sel);
        return REF_HZ / (16 * BAUD_TAB[sel]);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: one nanosecond after each rising edge
    always @(posedge clk) begin
        bit n_ref, n_os, n_bit;
        #1;
        if (rst) begin
            m_phase = 0; m_cnt = 0; m_bcnt = 0; m_sel = int'(baud_sel);
            m_ref = 0; m_os = 0; m_bit = 0;
            cyc = 0; ref_total = 0; last_ref = -1;
            n_ref = 0; n_os = 0; n_bit = 0;
        end else begin
            cyc++;
            m_phase += 151;
            n_ref = (m_phase >= 4096);
            if (n_ref) m_phase -= 4096;
            n_os = 0; n_bit = 0;
            if (int'(baud_sel) != m_sel) begin
                m_sel = int'(baud_sel); m_cnt = 0; m_bcnt = 0;
            end else begin
                if (m_ref) begin
                    if (m_cnt == div_of(m_sel) - 1) begin m_cnt = 0; n_os = 1; end
                    else m_cnt++;
                end
                if (m_os) begin
                    if (m_bcnt == 15) begin m_bcnt = 0; n_bit = 1; end
                    else m_bcnt++;
                end
            end
        end
        m_ref = n_ref; m_os = n_os; m_bit = n_bit;
        if (ref_tick !== m_ref) err_ref++;
        if (os_tick  !== m_os)  err_os++;
        if (bit_tick !== m_bit) err_bit++;
        if (!rst && ref_tick) begin
            ref_total++; ref_win++;
            if (last_ref >= 0) begin
                if (cyc - last_ref < gap_min) gap_min = cyc - last_ref;
                if (cyc - last_ref > gap_max) gap_max = cyc - last_ref;
            end
            last_ref = cyc;
        end
        if (!rst && os_tick)  os_win++;
        if (!rst && bit_tick) bit_win++;
    end

    initial begin
        repeat (250000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n, win, cnt_refs;
        // R1: reset state
        repeat (4) @(negedge clk);
        check(ref_tick == 0 && os_tick == 0 && bit_tick == 0, "R1 outputs low in reset",
              {ref_tick, os_tick, bit_tick}, 0);
        rst = 1'b0;

        // R2: long-run strobe count after exactly 40960 edges
        repeat (40960) @(posedge clk);
        #2;
        check(ref_total == 1510, "R2 reference count", ref_total, 1510);
        check(err_ref == 0, "R2 reference cycle model", err_ref, 0);
        check(gap_min == 27 && gap_max == 28, "R3 strobe spacing", gap_min * 100 + gap_max, 2728);

        // R4/R5: walk every rate code
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            baud_sel = 3'(i);
            n = div_of(i);
            win = 28 * 16 * n + 100;
            ref_win = 0; os_win = 0; bit_win = 0;
            repeat (win) @(posedge clk);
            #2;
            check((os_win - ref_win / n) <= 1 && (ref_win / n - os_win) <= 1,
                  $sformatf("R4 os count code %0d", i), os_win, ref_win / n);
            check(bit_win >= 1 && bit_win == os_win / 16,
                  $sformatf("R5 bit count code %0d", i), bit_win, os_win / 16);
        end
        check(err_os == 0, "R4 os cycle model", err_os, 0);
        check(err_bit == 0, "R5 bit cycle model", err_bit, 0);

        // R6: change mid-count, first os after exactly N strobes
        @(negedge clk);
        baud_sel = 3'd4;
        repeat (500) @(posedge clk);
        @(negedge clk);
        baud_sel = 3'd5;
        @(posedge clk); #1;
        check(os_tick == 0 && bit_tick == 0, "R6 no tick after change", {os_tick, bit_tick}, 0);
        cnt_refs = ref_tick;
        while (!os_tick) begin
            @(posedge clk); #1;
            if (ref_tick) cnt_refs++;
        end
        check(cnt_refs == 24, "R6 strobes to first os", cnt_refs, 24);

        // R7 plus all cycle models after the change
        repeat (2000) @(posedge clk);
        #2;
        check(err_os == 0 && err_bit == 0 && err_ref == 0, "R7 cycle model after change",
              err_os + err_bit + err_ref, 0);

        // R1: reset mid-run restarts
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(ref_tick == 0 && os_tick == 0 && bit_tick == 0, "R1 reset mid-run",
              {ref_tick, os_tick, bit_tick}, 0);
        rst = 1'b0;
        repeat (28) @(posedge clk);
        #2;
        check(ref_total == 1, "R1 first strobe on edge 28", ref_total, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule